// File: doc/BRIEF.md
# Pixel Path Test Capture Unit

This unit sits on a video pixel pipeline and gives diagnostic software a view of the path. Two pixels arrive together on each load strobe. The unit serializes them into a stream of one pixel per clock, A first and then B. It carries each pixel through a fixed-latency video path to the DAC code outputs. That path widens each 8-bit colour to a 10-bit DAC code. Two capture registers watch the stream. The pixel test register samples the red byte at the pixel port. The DAC test register samples the red DAC code as it enters the output register. A third register, of three host-written bits, holds sync, blank and a spare PLL-control bit.

A two-bit operating mode selects how the registers behave:

- **Mode 0 (normal):** both registers follow every pixel.
- **Mode 1 (trigger):** a pixel is captured only when its red bit 7 makes an edge against the previous serialized pixel. The polarity input selects a rising or a falling edge. A trigger flag travels down the pipeline with the pixel, so both registers hold that same pixel.
- **Mode 2 (RAM port test):** the pixel register behaves as in mode 0, and the DAC register changes only by host write.
- **Mode 3 (DAC test):** the host-written DAC test value drives all three DAC code outputs. The sync and blank test bits drive the sync and blank outputs.

Top module: `pixtest_capture`

## Requirements
- R1: While `rst` is high and after it falls, before any other stimulus, every output is 0 and all three test registers read back as 0.
- R2: A pair loaded on a clock edge leaves the DAC outputs with `dac_valid_o` high. Pixel A appears on the LAT-th following edge (LAT=4) and pixel B one edge later. Each code is `{colour byte, 2'b00}`. Sync and blank go with both pixels. Pixel words pack red in bits 23:16, green in 15:8 and blue in 7:0. Loads come at most every second cycle.
- R3: In mode 0, the pixel test register holds the red byte of the most recent valid pixel. The DAC test register holds the red code of the most recent pixel that reached the DAC outputs.
- R4: In mode 1 with `trig_pol_i`=0, a pixel is captured only if its bit 23 is 1 and the previous serialized pixel's bit 23 was 0. Both registers capture that same pixel.
- R5: In mode 1 with `trig_pol_i`=1, the capture condition is a falling edge of bit 23 instead.
- R6: Edge detection also compares pixel A of a pair with pixel B of the pair before it.
- R7: In mode 1, pixels without the selected edge leave both registers unchanged. A host write to the pixel test register (select 0) has no effect in any mode.
- R8: In mode 2, the pixel test register follows every valid pixel, and the DAC test register changes only by host write. The video outputs behave as in mode 0.
- R9: In mode 3, one edge after a write, `dac_r_o`, `dac_g_o` and `dac_b_o` all equal the DAC test register. `dac_sync_o` equals sync/blank test bit 0, `dac_blank_o` equals bit 1, and `dac_valid_o` is 0.
- R10: Any change of `mode_i` drops every trigger flag still in the pipeline. A pixel triggered before the change is therefore never captured at the DAC stage afterwards.
- R11: Host select codes are 0 for the pixel test register, 1 for the DAC test register (10 bits), 2 for the sync/blank/PLL register (3 bits) and 3 for none. `rd_data_o` shows the register chosen by `rd_sel_i` one edge later, zero-extended; select 3 reads 0. A DAC test write outside mode 3 is readable until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Operating mode 0..3 |
| trig_pol_i | input | 1 | Trigger edge: 0 rising, 1 falling |
| pair_load_i | input | 1 | Load strobe for a pixel pair |
| pix_a_i | input | 24 | First pixel of the pair (R,G,B bytes) |
| pix_b_i | input | 24 | Second pixel of the pair |
| sync_i | input | 1 | Sync for the pair, active high |
| blank_i | input | 1 | Blank for the pair, active high |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 2 | Host write target select |
| host_wdata_i | input | 10 | Host write data |
| rd_sel_i | input | 2 | Host read select |
| rd_data_o | output | 10 | Registered read data |
| dac_valid_o | output | 1 | A video pixel is on the DAC outputs |
| dac_r_o | output | 10 | Red DAC code |
| dac_g_o | output | 10 | Green DAC code |
| dac_b_o | output | 10 | Blue DAC code |
| dac_sync_o | output | 1 | Sync to the DAC |
| dac_blank_o | output | 1 | Blank to the DAC |

## Verification
On every cycle, the assertions check the following:

- Each load puts pixel A at the head of the stream.
- The pixel register tracks the stream in mode 0.
- The pixel register stays still in mode 1 without a trigger.
- The DAC register changes only by host write in mode 2.
- Mode 3 drives the host values onto the DAC outputs.
- A mode change leaves no trigger flag in flight.

The bench scenarios cover what the assertions cannot. They choose the red bit 7 sequences that single out the captured pixel: an edge across a pair boundary, a falling edge under the opposite polarity, and repeated patterns without an edge. They also show that a pixel triggered just before two mode changes is not captured later. The scoreboard confirms that the video stream keeps its order and codes through every mode except 3.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_TRIG   = 2'd1,
    MODE_RAMTST = 2'd2,
    MODE_DACTST = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SEL_PIX  = 2'd0,
    SEL_DAC  = 2'd1,
    SEL_SBP  = 2'd2,
    SEL_NONE = 2'd3
  } hsel_e;
endpackage

// File: rtl/ptc_serializer.sv
module ptc_serializer #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [PIX_W-1:0] a_i,
  input  logic [PIX_W-1:0] b_i,
  input  logic             sync_i,
  input  logic             blank_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             sync_o,
  output logic             blank_o,
  output logic             valid_o
);
  logic [PIX_W-1:0] hold_q;
  logic             hold_sync_q;
  logic             hold_blank_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_o        <= '0;
      sync_o       <= 1'b0;
      blank_o      <= 1'b0;
      valid_o      <= 1'b0;
      hold_q       <= '0;
      hold_sync_q  <= 1'b0;
      hold_blank_q <= 1'b0;
      pend_q       <= 1'b0;
    end else if (load_i) begin
      pix_o        <= a_i;
      sync_o       <= sync_i;
      blank_o      <= blank_i;
      valid_o      <= 1'b1;
      hold_q       <= b_i;
      hold_sync_q  <= sync_i;
      hold_blank_q <= blank_i;
      pend_q       <= 1'b1;
    end else if (pend_q) begin
      pix_o   <= hold_q;
      sync_o  <= hold_sync_q;
      blank_o <= hold_blank_q;
      valid_o <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ptc_edge_trig.sv
module ptc_edge_trig (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic bit_i,
  input  logic pol_i,
  input  logic arm_i,
  output logic trig_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
    end else if (valid_i) begin
      prev_q <= bit_i;
    end
  end

  always_comb begin
    if (pol_i) trig_o = arm_i & valid_i & prev_q & ~bit_i;
    else       trig_o = arm_i & valid_i & ~prev_q & bit_i;
  end
endmodule

// File: rtl/ptc_video_pipe.sv
module ptc_video_pipe #(
  parameter int CW  = 8,
  parameter int DW  = 10,
  parameter int LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [3*CW-1:0]   pix_i,
  input  logic              sync_i,
  input  logic              blank_i,
  input  logic              trig_i,
  input  logic              clr_i,
  input  logic              force_i,
  input  logic [DW-1:0]     tst_code_i,
  input  logic              tst_sync_i,
  input  logic              tst_blank_i,
  output logic              tap_valid_o,
  output logic              tap_trig_o,
  output logic [DW-1:0]     tap_red_o,
  output logic [LAT-2:0]    trig_vec_o,
  output logic              dac_valid_o,
  output logic [DW-1:0]     dac_r_o,
  output logic [DW-1:0]     dac_g_o,
  output logic [DW-1:0]     dac_b_o,
  output logic              dac_sync_o,
  output logic              dac_blank_o
);
  localparam int NSTG  = LAT - 1;
  localparam int PIX_W = 3 * CW;
  localparam int PAD   = DW - CW;

  typedef struct packed {
    logic             v;
    logic             t;
    logic             s;
    logic             b;
    logic [PIX_W-1:0] p;
  } stage_t;

  stage_t        head;
  stage_t        stg_q [NSTG];
  stage_t        tail;
  logic [DW-1:0] code [3];

  always_comb begin
    head = '{v: valid_i, t: trig_i & ~clr_i, s: sync_i, b: blank_i, p: pix_i};
    tail = stg_q[NSTG-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSTG; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= head;
      for (int i = 1; i < NSTG; i++) begin
        stg_q[i] <= stg_q[i-1];
        if (clr_i) stg_q[i].t <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NSTG; i++) begin : g_tvec
    assign trig_vec_o[i] = stg_q[i].t;
  end

  // channel 0 blue, 1 green, 2 red
  for (genvar c = 0; c < 3; c++) begin : g_widen
    logic [DW-1:0] raw;
    assign raw     = DW'(tail.p[c*CW +: CW]);
    assign code[c] = raw << PAD;
  end

  assign tap_valid_o = tail.v;
  assign tap_trig_o  = tail.t;
  assign tap_red_o   = code[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_valid_o <= 1'b0;
      dac_r_o     <= '0;
      dac_g_o     <= '0;
      dac_b_o     <= '0;
      dac_sync_o  <= 1'b0;
      dac_blank_o <= 1'b0;
    end else if (force_i) begin
      dac_valid_o <= 1'b0;
      dac_r_o     <= tst_code_i;
      dac_g_o     <= tst_code_i;
      dac_b_o     <= tst_code_i;
      dac_sync_o  <= tst_sync_i;
      dac_blank_o <= tst_blank_i;
    end else begin
      dac_valid_o <= tail.v;
      dac_r_o     <= code[2];
      dac_g_o     <= code[1];
      dac_b_o     <= code[0];
      dac_sync_o  <= tail.s;
      dac_blank_o <= tail.b;
    end
  end
endmodule

// File: rtl/ptc_test_regs.sv
module ptc_test_regs
  import ptc_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  mode_e         mode_i,
  input  logic          chg_i,
  input  logic          ser_valid_i,
  input  logic [CW-1:0] ser_red_i,
  input  logic          trig0_i,
  input  logic          tap_valid_i,
  input  logic          tap_trig_i,
  input  logic [DW-1:0] tap_code_i,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    rd_sel_i,
  output logic [CW-1:0] pix_tst_o,
  output logic [DW-1:0] dac_tst_o,
  output logic [2:0]    sbp_o,
  output logic [DW-1:0] rd_data_o
);
  logic cap_pix;
  logic cap_dac;

  always_comb begin
    cap_pix = (mode_i == MODE_TRIG) ? trig0_i : ser_valid_i;
    unique case (mode_i)
      MODE_NORMAL: cap_dac = tap_valid_i;
      MODE_TRIG:   cap_dac = tap_valid_i & tap_trig_i & ~chg_i;
      default:     cap_dac = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_tst_o <= '0;
      dac_tst_o <= '0;
      sbp_o     <= '0;
    end else begin
      if (cap_pix) pix_tst_o <= ser_red_i;
      if (cap_dac) dac_tst_o <= tap_code_i;
      else if (we_i && hsel_e'(sel_i) == SEL_DAC) dac_tst_o <= wdata_i;
      if (we_i && hsel_e'(sel_i) == SEL_SBP) sbp_o <= wdata_i[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else begin
      unique case (hsel_e'(rd_sel_i))
        SEL_PIX: rd_data_o <= DW'(pix_tst_o);
        SEL_DAC: rd_data_o <= dac_tst_o;
        SEL_SBP: rd_data_o <= DW'(sbp_o);
        default: rd_data_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pixtest_capture.sv
module pixtest_capture
  import ptc_pkg::*;
#(
  parameter int CW  = 8,
  parameter int DW  = 10,
  parameter int LAT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode_i,
  input  logic            trig_pol_i,
  input  logic            pair_load_i,
  input  logic [3*CW-1:0] pix_a_i,
  input  logic [3*CW-1:0] pix_b_i,
  input  logic            sync_i,
  input  logic            blank_i,
  input  logic            host_we_i,
  input  logic [1:0]      host_sel_i,
  input  logic [DW-1:0]   host_wdata_i,
  input  logic [1:0]      rd_sel_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            dac_valid_o,
  output logic [DW-1:0]   dac_r_o,
  output logic [DW-1:0]   dac_g_o,
  output logic [DW-1:0]   dac_b_o,
  output logic            dac_sync_o,
  output logic            dac_blank_o
);
  localparam int PIX_W = 3 * CW;

  mode_e            mode;
  logic [1:0]       mode_q;
  logic             chg;
  logic [PIX_W-1:0] ser_pix;
  logic             ser_sync, ser_blank, ser_valid;
  logic             trig0;
  logic             tap_valid, tap_trig;
  logic [DW-1:0]    tap_red;
  logic [LAT-2:0]   trig_vec;
  logic [CW-1:0]    pix_tst;
  logic [DW-1:0]    dac_tst;
  logic [2:0]       sbp;

  assign mode = mode_e'(mode_i);
  assign chg  = (mode_i != mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 2'd0;
    else     mode_q <= mode_i;
  end

  ptc_serializer #(.PIX_W(PIX_W)) i_ser (
    .clk(clk), .rst(rst), .load_i(pair_load_i), .a_i(pix_a_i), .b_i(pix_b_i),
    .sync_i(sync_i), .blank_i(blank_i), .pix_o(ser_pix), .sync_o(ser_sync),
    .blank_o(ser_blank), .valid_o(ser_valid)
  );

  ptc_edge_trig i_trig (
    .clk(clk), .rst(rst), .valid_i(ser_valid), .bit_i(ser_pix[PIX_W-1]),
    .pol_i(trig_pol_i), .arm_i((mode == MODE_TRIG) && !chg), .trig_o(trig0)
  );

  ptc_video_pipe #(.CW(CW), .DW(DW), .LAT(LAT)) i_pipe (
    .clk(clk), .rst(rst), .valid_i(ser_valid), .pix_i(ser_pix), .sync_i(ser_sync),
    .blank_i(ser_blank), .trig_i(trig0), .clr_i(chg),
    .force_i(mode == MODE_DACTST), .tst_code_i(dac_tst), .tst_sync_i(sbp[0]),
    .tst_blank_i(sbp[1]), .tap_valid_o(tap_valid), .tap_trig_o(tap_trig),
    .tap_red_o(tap_red), .trig_vec_o(trig_vec), .dac_valid_o(dac_valid_o),
    .dac_r_o(dac_r_o), .dac_g_o(dac_g_o), .dac_b_o(dac_b_o),
    .dac_sync_o(dac_sync_o), .dac_blank_o(dac_blank_o)
  );

  ptc_test_regs #(.CW(CW), .DW(DW)) i_regs (
    .clk(clk), .rst(rst), .mode_i(mode), .chg_i(chg), .ser_valid_i(ser_valid),
    .ser_red_i(ser_pix[PIX_W-1 -: CW]), .trig0_i(trig0), .tap_valid_i(tap_valid),
    .tap_trig_i(tap_trig), .tap_code_i(tap_red), .we_i(host_we_i),
    .sel_i(host_sel_i), .wdata_i(host_wdata_i), .rd_sel_i(rd_sel_i),
    .pix_tst_o(pix_tst), .dac_tst_o(dac_tst), .sbp_o(sbp), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int CW   = 8,
  parameter int DW   = 10,
  parameter int NSTG = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      mode_i,
  input logic [1:0]      mode_q,
  input logic            pair_load_i,
  input logic [3*CW-1:0] pix_a_i,
  input logic [3*CW-1:0] ser_pix,
  input logic            ser_valid,
  input logic            trig0,
  input logic [NSTG-1:0] trig_vec,
  input logic [CW-1:0]   pix_tst,
  input logic [DW-1:0]   dac_tst,
  input logic [2:0]      sbp,
  input logic            host_we_i,
  input logic [1:0]      host_sel_i,
  input logic            dac_valid_o,
  input logic [DW-1:0]   dac_r_o,
  input logic            dac_sync_o,
  input logic            dac_blank_o
);
  AST_LOAD_HEAD_A: assert property (@(posedge clk) disable iff (rst)
    pair_load_i |=> (ser_valid && ser_pix == $past(pix_a_i))); // R2

  AST_NORMAL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0 && ser_valid) |=> (pix_tst == $past(ser_pix[3*CW-1 -: CW]))); // R3

  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1 && !trig0) |=> $stable(pix_tst)); // R7

  AST_RAMTST_HOST_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd2 && !(host_we_i && host_sel_i == 2'd1)) |=> $stable(dac_tst)); // R8

  AST_DACTST_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd3) |=> (dac_r_o == $past(dac_tst) && dac_sync_o == $past(sbp[0])
                          && dac_blank_o == $past(sbp[1]) && !dac_valid_o)); // R9

  AST_CHG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (mode_i != mode_q) |=> ($countones(trig_vec) == 0)); // R10
endmodule

bind pixtest_capture ptc_checker #(.CW(CW), .DW(DW), .NSTG(LAT-1)) i_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .mode_q(mode_q), .pair_load_i(pair_load_i),
  .pix_a_i(pix_a_i), .ser_pix(ser_pix), .ser_valid(ser_valid), .trig0(trig0),
  .trig_vec(trig_vec), .pix_tst(pix_tst), .dac_tst(dac_tst), .sbp(sbp),
  .host_we_i(host_we_i), .host_sel_i(host_sel_i), .dac_valid_o(dac_valid_o),
  .dac_r_o(dac_r_o), .dac_sync_o(dac_sync_o), .dac_blank_o(dac_blank_o)
);

// File: tb/test_pixtest_capture.sv
module test_pixtest_capture;
  localparam int CLK_P = 10;
  localparam int CW    = 8;
  localparam int DW    = 10;
  localparam int LAT   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      mode = 2'd0;
  logic            pol = 1'b0;
  logic            load = 1'b0;
  logic [3*CW-1:0] pa = '0, pb = '0;
  logic            sy = 1'b0, bl = 1'b0;
  logic            we = 1'b0;
  logic [1:0]      wsel = 2'd3;
  logic [DW-1:0]   wdata = '0;
  logic [1:0]      rsel = 2'd3;
  logic [DW-1:0]   rdata;
  logic            dvalid, dsync, dblank;
  logic [DW-1:0]   dr, dg, db;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [3*DW+1:0] exp_q [$];

  always #(CLK_P/2) clk = ~clk;

  pixtest_capture #(.CW(CW), .DW(DW), .LAT(LAT)) i_pixtest_capture (
    .clk(clk), .rst(rst), .mode_i(mode), .trig_pol_i(pol), .pair_load_i(load),
    .pix_a_i(pa), .pix_b_i(pb), .sync_i(sy), .blank_i(bl), .host_we_i(we),
    .host_sel_i(wsel), .host_wdata_i(wdata), .rd_sel_i(rsel), .rd_data_o(rdata),
    .dac_valid_o(dvalid), .dac_r_o(dr), .dac_g_o(dg), .dac_b_o(db),
    .dac_sync_o(dsync), .dac_blank_o(dblank)
  );

  function automatic logic [DW-1:0] cd(input logic [CW-1:0] v);
    return DW'(v) << (DW - CW);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_pair(input logic [23:0] a, input logic [23:0] b,
                           input logic s, input logic k);
    @(negedge clk);
    pa = a; pb = b; sy = s; bl = k; load = 1'b1;
    exp_q.push_back({cd(a[23:16]), cd(a[15:8]), cd(a[7:0]), s, k});
    exp_q.push_back({cd(b[23:16]), cd(b[15:8]), cd(b[7:0]), s, k});
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic hwrite(input logic [1:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; wsel = s; wdata = d;
    @(negedge clk);
    we = 1'b0; wsel = 2'd3;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] s, input logic [DW-1:0] exp);
    @(negedge clk);
    rsel = s;
    @(negedge clk);
    chk(tag, 32'(rdata), 32'(exp));
  endtask

  task automatic flush();
    repeat (LAT + 3) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && dvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R2: unexpected pixel actual %0h expected none", {dr, dg, db, dsync, dblank});
      end else begin
        logic [31:0] item;
        item = exp_q.pop_front();
        chk("R2 video word", {dr, dg, db, dsync, dblank}, item);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        done = 1'b1;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {dvalid, dr, dg, db, dsync, dblank, rdata}, 32'd0);
    rst = 1'b0;
    chk("R1 outputs after reset", {dvalid, dr, dsync, dblank}, 32'd0);
    rd_chk("R1 pixel reg", 2'd0, '0);
    rd_chk("R1 dac reg", 2'd1, '0);
    rd_chk("R1 sbp reg", 2'd2, '0);

    // normal mode stream
    send_pair(24'h31_42_53, 24'h8F_01_FE, 1'b0, 1'b1);
    send_pair(24'hC4_77_10, 24'h2B_AA_55, 1'b1, 1'b0);
    send_pair(24'hFF_00_80, 24'h10_20_30, 1'b0, 1'b0);
    flush();
    rd_chk("R3 pixel reg follows", 2'd0, 10'h010);
    rd_chk("R3 dac reg follows", 2'd1, cd(8'h10));

    // trigger mode, rising
    @(negedge clk); mode = 2'd1; pol = 1'b0;
    send_pair(24'h05_11_22, 24'hA5_33_44, 1'b0, 1'b0);
    flush();
    rd_chk("R4 rising pixel reg", 2'd0, 10'h0A5);
    rd_chk("R4 rising dac reg", 2'd1, cd(8'hA5));
    hwrite(2'd0, 10'h0FF);
    rd_chk("R7 pixel reg write ignored", 2'd0, 10'h0A5);
    hwrite(2'd1, 10'h2AA);
    rd_chk("R11 dac reg host write", 2'd1, 10'h2AA);
    send_pair(24'hC3_00_00, 24'h33_00_00, 1'b0, 1'b0);
    send_pair(24'h22_00_00, 24'h7F_00_00, 1'b0, 1'b0);
    flush();
    rd_chk("R7 no edge pixel hold", 2'd0, 10'h0A5);
    rd_chk("R7 no edge dac hold", 2'd1, 10'h2AA);

    // edge across pair boundary (prev B red 7F, bit7 0)
    send_pair(24'h9E_01_02, 24'h9F_03_04, 1'b1, 1'b1);
    flush();
    rd_chk("R6 boundary pixel reg", 2'd0, 10'h09E);
    rd_chk("R6 boundary dac reg", 2'd1, cd(8'h9E));

    // falling polarity
    @(negedge clk); pol = 1'b1;
    send_pair(24'hF0_00_00, 24'h41_00_00, 1'b0, 1'b0);
    flush();
    rd_chk("R5 falling pixel reg", 2'd0, 10'h041);
    rd_chk("R5 falling dac reg", 2'd1, cd(8'h41));

    // mode change drops pending trigger
    send_pair(24'h81_00_00, 24'h12_00_00, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk); mode = 2'd2;
    @(negedge clk); mode = 2'd1;
    flush();
    rd_chk("R10 pixel reg got trigger", 2'd0, 10'h012);
    rd_chk("R10 dac reg not stale", 2'd1, cd(8'h41));

    // RAM port test mode
    @(negedge clk); mode = 2'd2;
    send_pair(24'h66_10_10, 24'h77_20_20, 1'b1, 1'b0);
    flush();
    rd_chk("R8 pixel reg follows", 2'd0, 10'h077);
    rd_chk("R8 dac reg held", 2'd1, cd(8'h41));
    hwrite(2'd1, 10'h3A5);
    rd_chk("R8 dac reg host value", 2'd1, 10'h3A5);

    // DAC test mode
    @(negedge clk); mode = 2'd3;
    hwrite(2'd1, 10'h155);
    hwrite(2'd2, 10'h005);
    @(negedge clk);
    chk("R9 codes forced", {2'b0, dr, dg, db}, {2'b0, 10'h155, 10'h155, 10'h155});
    chk("R9 sync blank valid", {dsync, dblank, dvalid}, 32'b100);
    hwrite(2'd2, 10'h002);
    @(negedge clk);
    chk("R9 sync blank swap", {dsync, dblank, dvalid}, 32'b010);
    rd_chk("R11 sbp readback", 2'd2, 10'h002);
    rd_chk("R11 select 3 reads zero", 2'd3, '0);

    // back to normal
    @(negedge clk); mode = 2'd0;
    send_pair(24'hB4_01_01, 24'h5A_02_02, 1'b0, 1'b1);
    flush();
    rd_chk("R3 pixel reg after return", 2'd0, 10'h05A);
    rd_chk("R3 dac reg after return", 2'd1, cd(8'h5A));
    chk("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule